// File: doc/BRIEF.md
# Circular Acquisition Write Command Generator

This block drives the command side of a stream-to-memory DMA engine that stores acquisition samples into one fixed memory window, treated as a ring. Software hands over the window's first byte address and its end byte address (exclusive), an acquisition length in stream words (zero meaning "run until restarted") and a pre-trigger word count. A single-cycle start pulse captures all of these. The block then presents one write command at a time: a start address plus a bytes-to-transfer value.

The transfer size of every command is the space left between the current address and the window end, clamped to the largest legal transfer. The engine never gets a length that reaches past the window, so a long triggered run cannot spill into a neighbouring channel's window. The block counts stream words as the engine accepts them, with each word holding `WORD_BYTES` bytes. When a command's bytes are used up it steps the address forward. If the stepped address has reached or passed the window end, it goes back to the window start, and the next transfer size is again based on the whole window. The word count also marks the pre-trigger point and the final word of a finite acquisition, which closes the stream early with a last-word flag.

Top module: `acqwr_cmd_gen`

## Requirements
- R1: While reset is held and after its release, `cmd_valid`, `acq_done`, `tlast` and `pretrig_hit` are all low until the first start pulse.
- R2: One cycle after `acq_start`, `cmd_valid` is high with `cmd_addr` equal to `region_start` used as a byte address without any shift, and `cmd_btt` equal to `region_end - region_start` when that is below 2^(BTT_W-1).
- R3: When the remaining space is 2^(BTT_W-1) or more, `cmd_btt` is exactly 2^(BTT_W-1). This includes a space of 2^BTT_W, which must not be truncated to zero.
- R4: A command's bytes are used up on the word where the bytes counted for it (WORD_BYTES per `word_fire`) reach or exceed its `cmd_btt`. On the next cycle a new command appears at the old address plus those counted bytes, sized by the rule of R2/R3.
- R5: If that stepped address is greater than or equal to `region_end`, including an end address that is not a multiple of WORD_BYTES, the next command starts at `region_start`, and its size is computed from the full window.
- R6: After a command is accepted (`cmd_valid && cmd_ready`), `cmd_valid` stays low until the next boundary of R4, so exactly one command is issued per boundary.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_btt` hold their values.
- R8: With a nonzero length N, `tlast` is high, in the same cycle, on the N-th `word_fire` since the start pulse. From the next cycle `acq_done` is high and no further command is issued.
- R9: With a length of zero, `tlast` never rises, and commands keep cycling around the window.
- R10: With a nonzero pre-trigger count P, `pretrig_hit` is high, in the same cycle, on the P-th `word_fire` since the start pulse, and on no other word.
- R11: A start pulse discards all earlier state: a pending command is replaced, `acq_done` clears, and the word count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | Start pulse; captures window, length and pre-trigger count |
| region_start | input | ADDR_W | First byte address of the window |
| region_end | input | ADDR_W | End byte address of the window (exclusive) |
| acq_len_words | input | CNT_W | Acquisition length in words, 0 for continuous |
| pretrig_words | input | CNT_W | Pre-trigger point in words, 0 for none |
| word_fire | input | 1 | One stream word accepted by the engine this cycle |
| tlast | output | 1 | Current word is the final word of the acquisition |
| pretrig_hit | output | 1 | Current word is the pre-trigger word |
| acq_done | output | 1 | Finite acquisition has completed |
| cmd_valid | output | 1 | Command is presented |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_addr | output | ADDR_W | Command start byte address |
| cmd_btt | output | BTT_W | Command bytes to transfer |

## Verification
The properties assume that the engine raises `word_fire` only between accepting a command and the boundary word that ends it. They also assume that every window has `region_end` above `region_start`. Under those conditions, every command lies inside the captured window and holds a nonzero size. The bench follows both rules: it raises `word_fire` only after it has accepted a command, it sends exactly as many words as each command needs (or fewer, when a finite length ends the run), and it uses only windows with their end above their start.

// File: rtl/acqwr_pkg.sv
package acqwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } acqwr_state_e;

endpackage

// File: rtl/acqwr_btt_calc.sv
// Transfer size from the current address to the window end, clamped to
// the largest legal size (2^(BTT_W-1)). Wide arithmetic avoids truncation.
module acqwr_btt_calc #(
    parameter int ADDR_W = 32,
    parameter int BTT_W  = 23
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] lim_addr,
    output logic [BTT_W-1:0]  btt
);
    localparam logic [ADDR_W:0] MAX_SIZE = (ADDR_W+1)'(1) << (BTT_W-1);

    logic [ADDR_W:0] space;

    always_comb begin
        space = {1'b0, lim_addr} - {1'b0, cur_addr};
        if (space >= MAX_SIZE) begin
            btt = MAX_SIZE[BTT_W-1:0];
        end else begin
            btt = space[BTT_W-1:0];
        end
    end
endmodule

// File: rtl/acqwr_addr_step.sv
// Advance the write address by the bytes consumed; return to the window
// base when the result reaches or passes the (possibly unaligned) end.
module acqwr_addr_step #(
    parameter int ADDR_W = 32,
    parameter int ADV_W  = 24
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADV_W-1:0]  adv_bytes,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] lim_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              wrapped
);
    logic [ADDR_W:0] sum;

    always_comb begin
        sum = {1'b0, cur_addr} + (ADDR_W+1)'(adv_bytes);
        if (sum >= {1'b0, lim_addr}) begin
            nxt_addr = base_addr;
            wrapped  = 1'b1;
        end else begin
            nxt_addr = sum[ADDR_W-1:0];
            wrapped  = 1'b0;
        end
    end
endmodule

// File: rtl/acqwr_word_mark.sv
// Word-count markers: final word of a finite run and the pre-trigger word.
module acqwr_word_mark #(
    parameter int CNT_W = 32
) (
    input  logic             active,
    input  logic             fire,
    input  logic [CNT_W-1:0] words_done,
    input  logic [CNT_W-1:0] len_words,
    input  logic [CNT_W-1:0] pre_words,
    output logic             last_word,
    output logic             pre_word
);
    always_comb begin
        last_word = active && fire && (len_words != '0)
                    && (words_done == len_words - CNT_W'(1));
        pre_word  = active && fire && (pre_words != '0)
                    && (words_done == pre_words - CNT_W'(1));
    end
endmodule

// File: rtl/acqwr_cmd_gen.sv
module acqwr_cmd_gen
    import acqwr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BTT_W      = 23,
    parameter int CNT_W      = 32,
    parameter int WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_start,
    input  logic [ADDR_W-1:0] region_start,
    input  logic [ADDR_W-1:0] region_end,
    input  logic [CNT_W-1:0]  acq_len_words,
    input  logic [CNT_W-1:0]  pretrig_words,
    input  logic              word_fire,
    output logic              tlast,
    output logic              pretrig_hit,
    output logic              acq_done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BTT_W-1:0]  cmd_btt
);
    localparam int CONS_W = BTT_W + 1;
    localparam logic [CONS_W-1:0] WORD_STEP = CONS_W'(WORD_BYTES);

    typedef struct packed {
        acqwr_state_e      state;
        logic [ADDR_W-1:0] rgn_start;
        logic [ADDR_W-1:0] rgn_end;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  pre;
        logic [ADDR_W-1:0] addr;
        logic [BTT_W-1:0]  btt;
        logic [CONS_W-1:0] consumed;
        logic [CNT_W-1:0]  words;
    } acqwr_regs_t;

    acqwr_regs_t regs_d, regs_q;

    logic [BTT_W-1:0]  first_btt;
    logic [BTT_W-1:0]  step_btt;
    logic [CONS_W-1:0] cons_next;
    logic [ADDR_W-1:0] step_addr;
    logic              step_wrapped;
    logic              xfer_active;
    logic              last_w;
    logic              pre_w;
    logic [ADDR_W-1:0] rgn_start_w;
    logic [ADDR_W-1:0] rgn_end_w;

    assign xfer_active = (regs_q.state == ST_XFER);
    assign cons_next   = regs_q.consumed + WORD_STEP;

    acqwr_btt_calc #(.ADDR_W(ADDR_W), .BTT_W(BTT_W)) u_btt_first (
        .cur_addr (region_start),
        .lim_addr (region_end),
        .btt      (first_btt)
    );

    acqwr_addr_step #(.ADDR_W(ADDR_W), .ADV_W(CONS_W)) u_step (
        .cur_addr  (regs_q.addr),
        .adv_bytes (cons_next),
        .base_addr (regs_q.rgn_start),
        .lim_addr  (regs_q.rgn_end),
        .nxt_addr  (step_addr),
        .wrapped   (step_wrapped)
    );

    acqwr_btt_calc #(.ADDR_W(ADDR_W), .BTT_W(BTT_W)) u_btt_step (
        .cur_addr (step_addr),
        .lim_addr (regs_q.rgn_end),
        .btt      (step_btt)
    );

    acqwr_word_mark #(.CNT_W(CNT_W)) u_mark (
        .active     (xfer_active),
        .fire       (word_fire),
        .words_done (regs_q.words),
        .len_words  (regs_q.len),
        .pre_words  (regs_q.pre),
        .last_word  (last_w),
        .pre_word   (pre_w)
    );

    always_comb begin
        regs_d = regs_q;
        if (acq_start) begin
            regs_d.state     = ST_ISSUE;
            regs_d.rgn_start = region_start;
            regs_d.rgn_end   = region_end;
            regs_d.len       = acq_len_words;
            regs_d.pre       = pretrig_words;
            regs_d.addr      = region_start;
            regs_d.btt       = first_btt;
            regs_d.consumed  = '0;
            regs_d.words     = '0;
        end else begin
            unique case (regs_q.state)
                ST_ISSUE: begin
                    if (cmd_ready) begin
                        regs_d.state    = ST_XFER;
                        regs_d.consumed = '0;
                    end
                end
                ST_XFER: begin
                    if (word_fire) begin
                        regs_d.words = regs_q.words + CNT_W'(1);
                        if (last_w) begin
                            regs_d.state = ST_DONE;
                        end else if (cons_next >= CONS_W'(regs_q.btt)) begin
                            regs_d.state    = ST_ISSUE;
                            regs_d.addr     = step_addr;
                            regs_d.btt      = step_btt;
                            regs_d.consumed = '0;
                        end else begin
                            regs_d.consumed = cons_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmd_valid   = (regs_q.state == ST_ISSUE);
    assign cmd_addr    = regs_q.addr;
    assign cmd_btt     = regs_q.btt;
    assign acq_done    = (regs_q.state == ST_DONE);
    assign tlast       = last_w;
    assign pretrig_hit = pre_w;
    assign rgn_start_w = regs_q.rgn_start;
    assign rgn_end_w   = regs_q.rgn_end;

    logic unused_wrap;
    assign unused_wrap = step_wrapped;

endmodule

// File: rtl/acqwr_cmd_gen_chk.sv
module acqwr_cmd_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int BTT_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_start,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BTT_W-1:0]  cmd_btt,
    input logic              tlast,
    input logic              acq_done,
    input logic [ADDR_W-1:0] win_start,
    input logic [ADDR_W-1:0] win_end
);
    localparam logic [BTT_W-1:0] MAX_SIZE = BTT_W'(1) << (BTT_W-1);

    AST_BTT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_btt != '0) && (cmd_btt <= MAX_SIZE)); // R3

    AST_CMD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr >= win_start) && (cmd_addr < win_end)); // R5

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_addr} + (ADDR_W+1)'(cmd_btt) <= {1'b0, win_end})); // R4

    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !acq_start |=> !cmd_valid); // R6

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !acq_start
        |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_btt)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tlast && !acq_start |=> acq_done && !cmd_valid); // R8

endmodule

bind acqwr_cmd_gen acqwr_cmd_gen_chk #(.ADDR_W(ADDR_W), .BTT_W(BTT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_start (acq_start),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_btt   (cmd_btt),
    .tlast     (tlast),
    .acq_done  (acq_done),
    .win_start (rgn_start_w),
    .win_end   (rgn_end_w)
);

// File: tb/acqwr_cmd_gen_tb.sv
module acqwr_cmd_gen_tb;
    localparam int ADDR_W = 32;
    localparam int BTT_W  = 9;
    localparam int CNT_W  = 32;
    localparam int WB     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acq_start = 1'b0;
    logic [ADDR_W-1:0] region_start = '0;
    logic [ADDR_W-1:0] region_end = '0;
    logic [CNT_W-1:0]  acq_len_words = '0;
    logic [CNT_W-1:0]  pretrig_words = '0;
    logic              word_fire = 1'b0;
    logic              cmd_ready = 1'b0;
    logic              tlast, pretrig_hit, acq_done, cmd_valid;
    logic [ADDR_W-1:0] cmd_addr;
    logic [BTT_W-1:0]  cmd_btt;

    int n_checks = 0;
    int n_fail   = 0;
    int base_idx = 0;
    int tl_idx   = 0;
    int pt_idx   = 0;
    int tl_cnt   = 0;
    int pt_cnt   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acqwr_cmd_gen #(.ADDR_W(ADDR_W), .BTT_W(BTT_W), .CNT_W(CNT_W), .WORD_BYTES(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start),
        .region_start(region_start), .region_end(region_end),
        .acq_len_words(acq_len_words), .pretrig_words(pretrig_words),
        .word_fire(word_fire), .tlast(tlast), .pretrig_hit(pretrig_hit),
        .acq_done(acq_done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_btt(cmd_btt)
    );

    // start, end, expected first size
    localparam logic [95:0] VEC [6] = '{
        {32'h0000_1000, 32'h0000_1100, 32'd256},
        {32'h0000_1000, 32'h0000_1064, 32'd100},
        {32'h0000_3000, 32'h0000_3200, 32'd256},
        {32'h0000_4000, 32'h0000_4101, 32'd256},
        {32'h0000_5000, 32'h0000_50FF, 32'd255},
        {32'h8000_0000, 32'h8000_0010, 32'd16}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic start_acq(input logic [31:0] s, input logic [31:0] e,
                             input int len, input int pre);
        region_start  = s;
        region_end    = e;
        acq_len_words = CNT_W'(len);
        pretrig_words = CNT_W'(pre);
        acq_start     = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        base_idx = 0; tl_idx = 0; pt_idx = 0; tl_cnt = 0; pt_cnt = 0;
    endtask

    task automatic expect_cmd(input string req, input logic [31:0] a, input int b);
        chk(cmd_valid === 1'b1, req, longint'(cmd_valid), 1);
        chk(cmd_addr === a, req, longint'(cmd_addr), longint'(a));
        chk(cmd_btt === BTT_W'(b), req, longint'(cmd_btt), longint'(b));
    endtask

    task automatic accept();
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic send(input int n);
        for (int i = 1; i <= n; i++) begin
            word_fire = 1'b1;
            #1;
            if (tlast)       begin tl_cnt++; if (tl_idx == 0) tl_idx = base_idx + i; end
            if (pretrig_hit) begin pt_cnt++; if (pt_idx == 0) pt_idx = base_idx + i; end
            @(negedge clk);
        end
        word_fire = 1'b0;
        base_idx += n;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and after reset
        chk(cmd_valid === 1'b0 && acq_done === 1'b0, "R1 in reset", longint'({cmd_valid, acq_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_valid === 1'b0 && acq_done === 1'b0 && tlast === 1'b0 && pretrig_hit === 1'b0,
            "R1 after reset", longint'({cmd_valid, acq_done, tlast, pretrig_hit}), 0);

        // R2/R3: first command of each window (each start also exercises R11)
        for (int v = 0; v < 6; v++) begin
            start_acq(VEC[v][95:64], VEC[v][63:32], 0, 0);
            expect_cmd("R2/R3 first command", VEC[v][95:64], int'(VEC[v][31:0]));
        end

        // R4, R5, R6, R9: aligned 1024-byte window, continuous
        start_acq(32'h1000, 32'h1400, 0, 0);
        expect_cmd("R2 first", 32'h1000, 256);
        accept();
        send(31);
        chk(cmd_valid === 1'b0, "R6 quiet before boundary", longint'(cmd_valid), 0);
        send(1);
        expect_cmd("R4 second command", 32'h1100, 256);
        accept();
        send(32);
        expect_cmd("R4 third command", 32'h1200, 256);
        accept();
        send(32);
        expect_cmd("R4 fourth command", 32'h1300, 256);
        accept();
        send(32);
        expect_cmd("R5 wrap to start", 32'h1000, 256);
        chk(tl_cnt == 0, "R9 no last word when continuous", tl_cnt, 0);

        // R7: hold while not ready
        repeat (3) @(negedge clk);
        expect_cmd("R7 held", 32'h1000, 256);

        // R5: unaligned end, stepped address passes the end
        start_acq(32'h2000, 32'h2154, 0, 0);
        accept();
        send(32);
        expect_cmd("R4 remainder size", 32'h2100, 84);
        accept();
        send(10);
        chk(cmd_valid === 1'b0, "R6 quiet inside remainder", longint'(cmd_valid), 0);
        send(1);
        expect_cmd("R5 wrap on unaligned end, full-window size", 32'h2000, 256);

        // R8, R10: finite run of 40 words, pre-trigger at 5
        start_acq(32'h1000, 32'h1400, 40, 5);
        accept();
        send(32);
        expect_cmd("R4 mid-run command", 32'h1100, 256);
        accept();
        send(8);
        chk(tl_idx == 40 && tl_cnt == 1, "R8 last word position", tl_idx, 40);
        chk(pt_idx == 5 && pt_cnt == 1, "R10 pre-trigger position", pt_idx, 5);
        chk(acq_done === 1'b1, "R8 done raised", longint'(acq_done), 1);
        chk(cmd_valid === 1'b0, "R8 no further command", longint'(cmd_valid), 0);

        // R11: restart clears done and word count
        start_acq(32'h1000, 32'h1400, 3, 0);
        chk(acq_done === 1'b0, "R11 done cleared", longint'(acq_done), 0);
        accept();
        send(3);
        chk(tl_idx == 3, "R11 word count restarted", tl_idx, 3);

        // R11: pending command replaced by a new start
        start_acq(32'h1000, 32'h1400, 0, 0);
        start_acq(32'h6000, 32'h6030, 0, 0);
        expect_cmd("R11 pending command replaced", 32'h6000, 48);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule